// File: doc/BRIEF.md
# Erased Page Bit-Flip Classifier

This block sits behind a NAND flash page ECC decoder. After a page read it is handed the decoder's status byte with a one-cycle start pulse. When the status reports a correctable result, the block passes the corrected-error count straight through. When the status flags the page as uncorrectable, the block takes in the whole page as a stream of 32-bit words and counts the zero bits. This tells a freshly erased page that carries a few bit flips apart from a page that is really damaged.

The page streamed in holds 2048 data bytes and 64 spare bytes. Zero bits in both areas add into one total. If the total stays at or below half of the configured ECC strength, the page counts as erased: the block raises `erased`, and its consumer must then replace every data and spare byte with 0xFF. It also reports the number of flips as the corrected count. A larger total is an uncorrectable failure. The running total stops growing once it passes the threshold. Later words are still accepted and dropped, so the stream always runs to completion.

Top module: `erased_page_rescue`

## Requirements
- R1: If bit 7 of `ecc_status` is clear when `start` is taken, the following cycle shows `done` = 1, `corrected` = `ecc_status[5:0]` zero-extended, `erased` = 0 and `fail` = 0. Bit 6 has no effect and no word is requested.
- R2: If bit 7 of `ecc_status` is set when `start` is taken, `word_ready` goes high the following cycle. The block then accepts exactly 528 words (2048 data bytes plus 64 spare bytes, 4 bytes per word), each on a cycle where `word_valid` and `word_ready` are both high.
- R3: Each accepted word adds the number of its zero bits to the total. Words from the data area and words from the spare area count alike.
- R4: If the total after the last word is at most ECC_STRENGTH/2 (12 by default, boundary included), the result is `erased` = 1, `fail` = 0 and `corrected` = the total. `erased` and `fail` are never high together.
- R5: If the total exceeds ECC_STRENGTH/2, the result is `fail` = 1, `erased` = 0 and `corrected` = 0.
- R6: After the total passes the threshold, every remaining word is still accepted and discarded. `done` rises only in the cycle after the 528th word is accepted, and the result is the same whatever zeros those later words hold.
- R7: `done` is high for one cycle. `corrected`, `erased` and `fail` keep their values until the next accepted `start`.
- R8: A `start` that arrives while words are being taken in has no effect on the scan or on its result.
- R9: After reset, `done`, `erased`, `fail`, `word_ready` and `corrected` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that hands over the ECC status byte |
| ecc_status | input | 8 | Decoder status: bit 7 uncorrectable, bits 5:0 corrected count |
| word_valid | input | 1 | A page word is offered |
| word_ready | output | 1 | The block is taking page words |
| word_data | input | 32 | Page word, data area first, then spare area |
| done | output | 1 | One-cycle pulse: the result is valid |
| corrected | output | 8 | Corrected-bit count (or flip total for an erased page) |
| erased | output | 1 | Page is erased: its contents are to be replaced by 0xFF |
| fail | output | 1 | Page is uncorrectable |

## Verification
A correctable status produces its result one cycle after the clock edge that takes `start`. After an uncorrectable status, `word_ready` is high one cycle after that edge. The result and `done` follow one cycle after the edge that accepts the 528th word. The bench changes inputs on falling edges and reads outputs on the next falling edge after the edge in question, so each check sits exactly at the cycle where the result is due. It also checks that `done` is still low just before the last word and low again one cycle after its pulse.

// File: rtl/erp_pkg.sv
// Shared definitions for the erased page classifier.
// Assumes the ECC status byte layout fixed by the upstream decoder.
package erp_pkg;
    localparam int STAT_UNCORR_BIT = 7;
    localparam int STAT_CNT_MSB    = 5;
    localparam int STAT_CNT_LSB    = 0;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } erp_state_t;
endpackage

// File: rtl/erp_zero_count.sv
// Counts the zero bits of one word (population count of the inverted word).
// Purely combinational; assumes WORD_W >= 1.
module erp_zero_count #(
    parameter int WORD_W = 32,
    localparam int ZW    = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] word,
    output logic [ZW-1:0]     zeros
);
    // Sum the inverted bits of the word.
    always_comb begin
        zeros = '0;
        for (int i = 0; i < WORD_W; i++) begin
            zeros = zeros + ZW'(!word[i]);
        end
    end
endmodule

// File: rtl/erp_flip_accum.sv
// Running total of zero bits with an early stop once the threshold is passed.
// Offers the next-cycle total and overflow so the caller can finish on the
// same edge as the last word. Assumes clear and add_en are never both high.
module erp_flip_accum #(
    parameter int THRESH = 12,
    parameter int ZW     = 6,
    parameter int CNT_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic [ZW-1:0]    zeros,
    output logic [CNT_W-1:0] total_next,
    output logic             over_next
);
    logic [CNT_W-1:0] total_q;
    logic             over_q;

    // Stop adding as soon as the stored total is past the threshold.
    always_comb begin
        over_q     = (int'(total_q) > THRESH);
        total_next = total_q;
        if (add_en && !over_q) begin
            total_next = total_q + CNT_W'(zeros);
        end
        over_next  = (int'(total_next) > THRESH);
    end

    // Hold the running total; clear on a new scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (clear) begin
            total_q <= '0;
        end else begin
            total_q <= total_next;
        end
    end
endmodule

// File: rtl/erp_word_tracker.sv
// Counts accepted words of one page and flags the last one.
// Assumes NWORDS >= 2.
module erp_word_tracker #(
    parameter int NWORDS = 528,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic last
);
    logic [IDX_W-1:0] idx_q;

    // Flag the position of the final word.
    always_comb last = (idx_q == IDX_W'(NWORDS - 1));

    // Step the word index on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clear) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
        end
    end
endmodule

// File: rtl/erased_page_rescue.sv
// Top: classifies an ECC-uncorrectable page as erased-with-flips or failed.
// A correctable status is passed through without scanning. An uncorrectable
// status starts a scan of DATA_BYTES + SPARE_BYTES streamed in WORD_W words.
// Assumes the page size is a multiple of WORD_W/8 and that ECC_STRENGTH/2
// fits in the 8-bit result.
module erased_page_rescue #(
    parameter int WORD_W       = 32,
    parameter int DATA_BYTES   = 2048,
    parameter int SPARE_BYTES  = 64,
    parameter int ECC_STRENGTH = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        ecc_status,
    input  logic              word_valid,
    output logic              word_ready,
    input  logic [WORD_W-1:0] word_data,
    output logic              done,
    output logic [7:0]        corrected,
    output logic              erased,
    output logic              fail
);
    import erp_pkg::*;

    localparam int THRESH = ECC_STRENGTH / 2;
    localparam int NWORDS = (DATA_BYTES + SPARE_BYTES) / (WORD_W / 8);
    localparam int ZW     = $clog2(WORD_W + 1);
    localparam int CNT_W  = $clog2(THRESH + WORD_W + 1);

    erp_state_t       state_q;
    logic             accept;
    logic             take_start;
    logic             last_word;
    logic [ZW-1:0]    word_zeros;
    logic [CNT_W-1:0] total_next;
    logic             over_next;

    // Handshake and start qualification.
    always_comb begin
        word_ready = (state_q == ST_SCAN);
        accept     = word_valid && word_ready;
        take_start = start && (state_q == ST_IDLE);
    end

    erp_zero_count #(.WORD_W(WORD_W)) u_zero (
        .word  (word_data),
        .zeros (word_zeros)
    );

    erp_flip_accum #(.THRESH(THRESH), .ZW(ZW), .CNT_W(CNT_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (take_start),
        .add_en     (accept),
        .zeros      (word_zeros),
        .total_next (total_next),
        .over_next  (over_next)
    );

    erp_word_tracker #(.NWORDS(NWORDS)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (take_start),
        .advance (accept),
        .last    (last_word)
    );

    // Sequence control and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            done      <= 1'b0;
            corrected <= '0;
            erased    <= 1'b0;
            fail      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take_start) begin
                        erased    <= 1'b0;
                        fail      <= 1'b0;
                        corrected <= '0;
                        if (ecc_status[STAT_UNCORR_BIT]) begin
                            state_q <= ST_SCAN;
                        end else begin
                            done      <= 1'b1;
                            corrected <= 8'(ecc_status[STAT_CNT_MSB:STAT_CNT_LSB]);
                        end
                    end
                end
                ST_SCAN: begin
                    if (accept && last_word) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                        if (over_next) begin
                            fail      <= 1'b1;
                            corrected <= '0;
                        end else begin
                            erased    <= 1'b1;
                            corrected <= 8'(total_next);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/erp_checker.sv
// Temporal checks on the classifier ports, attached by bind.
module erp_checker #(
    parameter int THRESH = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [7:0] ecc_status,
    input logic       word_valid,
    input logic       word_ready,
    input logic       done,
    input logic [7:0] corrected,
    input logic       erased,
    input logic       fail
);
    p_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !word_ready && !ecc_status[7]) |=>
        (done && !erased && !fail && corrected == {2'b00, $past(ecc_status[5:0])}));

    p_scan_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !word_ready && ecc_status[7]) |=> (word_ready && !done));

    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(erased && fail));

    p_erased_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        erased |-> (int'(corrected) <= THRESH));

    p_fail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (corrected == 8'd0));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(word_valid && word_ready)) |=>
        ($stable(corrected) && $stable(erased) && $stable(fail)));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ready && start && !word_valid) |=> word_ready);
endmodule

bind erased_page_rescue erp_checker #(.THRESH(ECC_STRENGTH / 2)) u_erp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ecc_status (ecc_status),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .done       (done),
    .corrected  (corrected),
    .erased     (erased),
    .fail       (fail)
);

// File: tb/erased_page_rescue_bench.sv
module erased_page_rescue_bench;
    localparam int NW     = 528;
    localparam int THRESH = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  ecc_status = 8'h00;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic [31:0] word_data = 32'hFFFF_FFFF;
    logic        done;
    logic [7:0]  corrected;
    logic        erased;
    logic        fail;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    erased_page_rescue u_erased_page_rescue (
        .clk(clk), .rst_n(rst_n), .start(start), .ecc_status(ecc_status),
        .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
        .done(done), .corrected(corrected), .erased(erased), .fail(fail)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Page contents for each scenario.
    function automatic logic [31:0] page_word(input int mode, input int idx);
        logic [31:0] w = 32'hFFFF_FFFF;
        case (mode)
            1, 2: begin
                if (idx == 0)   w = 32'hFFFF_FFFE;
                if (idx == 100) w = ~32'h0000_0007;
                if (idx == 511) w = 32'h7FFF_FFFF;
                if (idx == 512) w = ~32'h0000_0003;
                if (idx == 527) w = ~32'h0000_001F;
                if (mode == 2 && idx == 300) w = ~32'h0000_0010;
            end
            3: begin
                if (idx == 0)   w = 32'h0000_0000;
                if (idx == 527) w = 32'h0000_0000;
            end
            4: if (idx == 520) w = ~32'h0000_000F;
            default: w = 32'hFFFF_FFFF;
        endcase
        return w;
    endfunction

    function automatic int expected_zeros(input int mode);
        int n = 0;
        for (int i = 0; i < NW; i++) begin
            logic [31:0] w = page_word(mode, i);
            for (int b = 0; b < 32; b++) if (!w[b]) n++;
        end
        return n;
    endfunction

    task automatic give_start(input logic [7:0] st);
        @(negedge clk);
        start = 1'b1;
        ecc_status = st;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Run one uncorrectable page; checks timing and the result.
    task automatic run_page(input string req, input int mode, input bit gaps, input bit restart);
        int tot = expected_zeros(mode);
        int ready_miss = 0;
        give_start(8'h80);
        check("R2", "word_ready after uncorrectable start", int'(word_ready), 1);
        for (int i = 0; i < NW; i++) begin
            if (gaps && (i % 7 == 3)) begin
                word_valid = 1'b0;
                @(negedge clk);
            end
            word_valid = 1'b1;
            word_data = page_word(mode, i);
            if (restart && i == 200) begin
                start = 1'b1;
                ecc_status = 8'h03;
            end
            if (!word_ready) ready_miss++;
            if (i == NW - 1) check("R6", "done before last word", int'(done), 0);
            @(negedge clk);
            start = 1'b0;
        end
        word_valid = 1'b0;
        check("R2", "ready lost during page", ready_miss, 0);
        check("R7", "done after last word", int'(done), 1);
        check(req, "erased", int'(erased), (tot <= THRESH) ? 1 : 0);
        check(req, "fail", int'(fail), (tot > THRESH) ? 1 : 0);
        check(req, "corrected", int'(corrected), (tot <= THRESH) ? tot : 0);
        check("R2", "ready low after page", int'(word_ready), 0);
        @(negedge clk);
        check("R7", "done pulse length", int'(done), 0);
        repeat (4) @(negedge clk);
        check("R7", "erased held", int'(erased), (tot <= THRESH) ? 1 : 0);
        check("R7", "corrected held", int'(corrected), (tot <= THRESH) ? tot : 0);
    endtask

    task automatic t_reset;
        check("R9", "done", int'(done), 0);
        check("R9", "erased", int'(erased), 0);
        check("R9", "fail", int'(fail), 0);
        check("R9", "word_ready", int'(word_ready), 0);
        check("R9", "corrected", int'(corrected), 0);
    endtask

    task automatic t_direct;
        give_start(8'h45);  // bit 6 set must not matter; count 5
        check("R1", "done", int'(done), 1);
        check("R1", "corrected", int'(corrected), 5);
        check("R1", "erased", int'(erased), 0);
        check("R1", "fail", int'(fail), 0);
        check("R1", "no word request", int'(word_ready), 0);
        word_valid = 1'b1;
        word_data = 32'h0;
        @(negedge clk);
        word_valid = 1'b0;
        check("R7", "done one cycle", int'(done), 0);
        check("R7", "corrected held", int'(corrected), 5);
        give_start(8'h3F);
        check("R1", "max count", int'(corrected), 63);
    endtask

    task automatic t_all_ones;    run_page("R4", 0, 1'b0, 1'b0); endtask
    task automatic t_boundary;    run_page("R4", 1, 1'b0, 1'b0); endtask  // exactly 12, R3 data+spare
    task automatic t_over_by_one; run_page("R5", 2, 1'b0, 1'b0); endtask  // 13
    task automatic t_early_stop;  run_page("R6", 3, 1'b0, 1'b0); endtask
    task automatic t_spare_only;  run_page("R3", 4, 1'b1, 1'b0); endtask
    task automatic t_start_ignored; run_page("R8", 1, 1'b1, 1'b1); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_all_ones();
        t_boundary();
        t_over_by_one();
        t_early_stop();
        t_spare_only();
        t_start_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule